// File: doc/BRIEF.md
# Synchronous Burst Memory Port

This block is the device-side front end of a multiplexed address/data synchronous burst bus. A host holds chip enable low and pulses address-valid low for one clock with the start address on the shared bus. On that edge the port latches the address and reads write enable to decide between a read and a write. It then holds a wait indication for a programmable number of cycles and moves one 16-bit word per clock, to or from an internal buffer RAM or a small register window.

A configuration register sets the initial latency and the burst length. The host writes this register through the same port. Bursts are either fixed length (4, 8, 16 or 32 words) with linear addressing, or continuous. A continuous burst wraps inside an aligned 32-word region of the buffer RAM. Stopping the clock at either level freezes the burst, and it resumes at the same word. Raising chip enable aborts the burst. The register window accepts only the first word of a write burst and flags any further word as an error.

Top module: `sbp_port`

## Requirements
- R1: After reset the wait output, output enable and error flag are low, and the configuration register reads 0x0014, meaning latency 4 and fixed bursts of 4 words.
- R2: A burst starts on a rising edge where chip enable and address-valid are both low. The bus value is captured as the start address, and write enable high selects a read while low selects a write. The wait output is high in the cycle after that edge.
- R3: With latency field L in configuration bits [2:0] (0 to 2 behave as 3), the wait output stays high for exactly L-1 cycles. The first word is transferred on the L-th rising edge after the address edge. Read data and output enable appear after edge L-1.
- R4: Configuration bits [6:4] set the burst length: 1 gives 4 words, 2 gives 8, 3 gives 16, 4 gives 32, and 0, 5, 6, 7 give a continuous burst. After its last word a fixed burst returns to idle, and the port ignores the bus until the next start.
- R5: A fixed burst steps the RAM address (bus bits [6:0]) by one per word and wraps from 127 to 0.
- R6: A continuous burst steps the address inside its aligned 32-word region and wraps from the region's last word to its first.
- R7: While the clock is held high or low, the burst position is frozen, and the word sequence continues without loss or repeat when the clock resumes.
- R8: Chip enable high drops output enable at once and returns the port to idle on the next edge, with the wait output low.
- R9: An address with bit 15 set targets the register window. In a write burst there, only the first word is stored (masked to bits [6:4] and [2:0]), and any later word is dropped and sets the error flag. The flag clears at the next burst start.
- R10: A read burst into the register window returns the configuration register on every word.
- R11: A configuration write takes effect from the next burst start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock; may be stopped at either level |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable sampled at the address edge, low for write |
| ad_in | input | 16 | Bus value into the port: address, then write data |
| ad_out | output | 16 | Read data, zero when not driving |
| ad_oe | output | 1 | High while the port drives read data |
| lat_busy | output | 1 | High during the initial latency |
| err | output | 1 | Extra word seen in a register-window write burst |

## Verification
Every result has a fixed edge relative to the address edge. The wait output rises after edge 0, and output enable and the first read word appear after edge L-1. The first write word is taken on edge L, and a fixed burst goes idle after edge L+N-1. The error flag rises after the edge that carries the second register word. The bench keeps a behavioural model that counts edges since the address edge, and it advances this model on each rising edge. It then compares every output 5 ns later. Read words are collected as they appear and checked against values worked out by hand, so stopped clocks and aborts only shift when words arrive, never their order.

// File: rtl/sbp_pkg.sv
`timescale 1ns/1ps
package sbp_pkg;
  localparam int BCNT_W = 6;
  localparam logic [15:0] CFG_RST  = 16'h0014;
  localparam logic [15:0] CFG_MASK = 16'h0077;

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_XFER} phase_t;

  // latency field to cycle count, small values raised to the minimum of 3
  function automatic logic [2:0] eff_latency(input logic [2:0] fld);
    return (fld < 3'd3) ? 3'd3 : fld;
  endfunction

  // burst code to word count, 0 meaning continuous
  function automatic logic [BCNT_W-1:0] burst_words(input logic [2:0] code);
    case (code)
      3'd1:    return BCNT_W'(4);
      3'd2:    return BCNT_W'(8);
      3'd3:    return BCNT_W'(16);
      3'd4:    return BCNT_W'(32);
      default: return '0;
    endcase
  endfunction

  function automatic logic wait_done(input logic [2:0] cnt, input logic [2:0] len);
    return cnt == (len - 3'd1);
  endfunction

  function automatic logic fixed_done(input logic [BCNT_W-1:0] cnt,
                                      input logic [BCNT_W-1:0] len);
    return (len != '0) && (cnt == (len - BCNT_W'(1)));
  endfunction
endpackage

// File: rtl/sbp_cfg.sv
`timescale 1ns/1ps
module sbp_cfg
  import sbp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_q,
  output logic [2:0]    lat_f,
  output logic [2:0]    blc
);
  localparam logic [DW-1:0] RST_V  = DW'(CFG_RST);
  localparam logic [DW-1:0] MASK_V = DW'(CFG_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= RST_V;
    else if (wr) cfg_q <= wdata & MASK_V;
  end

  assign lat_f = cfg_q[2:0];
  assign blc   = cfg_q[6:4];
endmodule

// File: rtl/sbp_ctrl.sv
`timescale 1ns/1ps
module sbp_ctrl
  import sbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       adv_n,
  input  logic       we_n,
  input  logic       reg_sel,
  input  logic [2:0] lat_f,
  input  logic [2:0] blc,
  output phase_t     phase,
  output logic       start,
  output logic       beat,
  output logic       is_wr,
  output logic       is_reg,
  output logic       cont,
  output logic       first_beat,
  output logic       err
);
  logic [2:0]        lat_len, wait_cnt;
  logic [BCNT_W-1:0] blen, bcnt;

  assign start      = !ce_n && !adv_n;
  assign beat       = (phase == PH_XFER) && !ce_n && adv_n;
  assign cont       = (blen == '0);
  assign first_beat = (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      wait_cnt <= '0;
      lat_len  <= 3'd4;
      blen     <= '0;
      bcnt     <= '0;
      is_wr    <= 1'b0;
      is_reg   <= 1'b0;
      err      <= 1'b0;
    end else if (ce_n) begin
      phase <= PH_IDLE;
    end else if (!adv_n) begin
      phase    <= PH_WAIT;
      wait_cnt <= 3'd1;
      lat_len  <= eff_latency(lat_f);
      blen     <= burst_words(blc);
      bcnt     <= '0;
      is_wr    <= !we_n;
      is_reg   <= reg_sel;
      err      <= 1'b0;
    end else begin
      unique case (phase)
        PH_WAIT: begin
          if (wait_done(wait_cnt, lat_len)) phase    <= PH_XFER;
          else                              wait_cnt <= wait_cnt + 3'd1;
        end
        PH_XFER: begin
          if (is_wr && is_reg && !first_beat) err <= 1'b1;
          if (bcnt != '1) bcnt <= bcnt + BCNT_W'(1);
          if (fixed_done(bcnt, blen)) phase <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbp_agen.sv
`timescale 1ns/1ps
module sbp_agen #(
  parameter int RAM_AW    = 7,
  parameter int REGION_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              beat,
  input  logic              cont,
  input  logic [RAM_AW-1:0] ld_addr,
  output logic [RAM_AW-1:0] cur
);
  logic [RAM_AW-1:0] nxt_lin, nxt_cont;

  assign nxt_lin = cur + RAM_AW'(1);

  generate
    if (REGION_AW >= RAM_AW) begin : g_whole
      assign nxt_cont = nxt_lin;
    end else begin : g_region
      assign nxt_cont = {cur[RAM_AW-1:REGION_AW], cur[REGION_AW-1:0] + REGION_AW'(1)};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur <= '0;
    else if (start) cur <= ld_addr;
    else if (beat)  cur <= cont ? nxt_cont : nxt_lin;
  end
endmodule

// File: rtl/sbp_ram.sv
`timescale 1ns/1ps
module sbp_ram #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sbp_port.sv
`timescale 1ns/1ps
module sbp_port
  import sbp_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int RAM_AW    = 7,
  parameter int REGION_AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             we_n,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             lat_busy,
  output logic             err
);
  localparam int REG_BIT = BUS_W - 1;

  phase_t            phase;
  logic              start, beat, is_wr, is_reg, cont, first_beat;
  logic              in_data, ram_we, cfg_wr, drop;
  logic [2:0]        lat_f, blc;
  logic [BUS_W-1:0]  cfg_q, ram_q;
  logic [RAM_AW-1:0] cur_addr;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^ad_in[REG_BIT-1:RAM_AW];

  sbp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .reg_sel(ad_in[REG_BIT]), .lat_f(lat_f), .blc(blc), .phase(phase),
    .start(start), .beat(beat), .is_wr(is_wr), .is_reg(is_reg),
    .cont(cont), .first_beat(first_beat), .err(err)
  );

  sbp_agen #(.RAM_AW(RAM_AW), .REGION_AW(REGION_AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .beat(beat), .cont(cont),
    .ld_addr(ad_in[RAM_AW-1:0]), .cur(cur_addr)
  );

  sbp_cfg #(.DW(BUS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(ad_in),
    .cfg_q(cfg_q), .lat_f(lat_f), .blc(blc)
  );

  sbp_ram #(.AW(RAM_AW), .DW(BUS_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(cur_addr), .wdata(ad_in), .rdata(ram_q)
  );

  // named transfer events
  assign in_data  = (phase == PH_XFER);
  assign lat_busy = (phase == PH_WAIT);
  assign ram_we   = beat && is_wr && !is_reg;
  assign cfg_wr   = beat && is_wr && is_reg && first_beat;
  assign drop     = beat && is_wr && is_reg && !first_beat;

  assign ad_oe  = in_data && !is_wr && !ce_n;
  assign ad_out = ad_oe ? (is_reg ? cfg_q : ram_q) : '0;
endmodule

// File: rtl/sbp_port_chk.sv
`timescale 1ns/1ps
module sbp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic adv_n,
  input logic start,
  input logic busy,
  input logic in_data,
  input logic err,
  input logic cfg_wr,
  input logic drop
);
  AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R2
  AST_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !ce_n && adv_n |=> busy); // R3
  AST_DATA_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_data) |-> $past(busy)); // R3
  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !busy && !in_data); // R8
  AST_DROP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err); // R9
  AST_CFG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_wr); // R9
endmodule

bind sbp_port sbp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .start(start),
  .busy(lat_busy), .in_data(in_data), .err(err), .cfg_wr(cfg_wr), .drop(drop)
);

// File: tb/sbp_port_test.sv
`timescale 1ns/1ps
module sbp_port_test;
  logic        clk = 1'b0, clk_run = 1'b1;
  logic        rst_n = 1'b0, ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe, lat_busy, err;

  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit done = 0;
  string cur_req = "R1 reset model";
  logic [15:0] rd_q[$];

  // reference model state
  int m_ph = -1, m_lat = 4, m_len = 4, m_words = 0, m_adr = 0, m_cfg = 'h14;
  bit m_wr = 0, m_reg = 0, m_err = 0;
  int mmem[128];

  sbp_port uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
                .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .lat_busy(lat_busy), .err(err));

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] dval(input logic [15:0] base, input int i);
    return 16'(int'(base) + i * 'h1111);
  endfunction

  function automatic logic [15:0] qat(input int k);
    return (rd_q.size() > k) ? rd_q[k] : 16'hxxxx;
  endfunction

  // model advance on each rising edge, then compare 5 ns later
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_ph = -1; m_err = 0; m_cfg = 'h14;
    end else if (ce_n) begin
      m_ph = -1;
    end else if (!adv_n) begin
      int code;
      m_ph = 0;
      m_lat = ((m_cfg & 7) < 3) ? 3 : (m_cfg & 7);
      code = (m_cfg >> 4) & 7;
      m_len = (code == 1) ? 4 : (code == 2) ? 8 : (code == 3) ? 16 : (code == 4) ? 32 : 0;
      m_wr = !we_n; m_reg = ad_in[15]; m_adr = int'(ad_in) & 127;
      m_words = 0; m_err = 0;
    end else if (m_ph >= 0) begin
      m_ph++;
      if (m_ph >= m_lat) begin
        if (m_wr) begin
          if (m_reg) begin
            if (m_words == 0) m_cfg = int'(ad_in) & 'h77;
            else m_err = 1;
          end else mmem[m_adr] = int'(ad_in);
        end
        m_words++;
        if (m_len == 0) m_adr = (m_adr / 32) * 32 + ((m_adr + 1) % 32);
        else            m_adr = (m_adr + 1) % 128;
        if (m_len != 0 && m_words == m_len) m_ph = -1;
      end
    end
    #5;
    begin
      bit e_busy, e_oe;
      int e_q;
      e_busy = (m_ph >= 0) && (m_ph < m_lat - 1);
      e_oe   = (m_ph >= m_lat - 1) && !m_wr && !ce_n;
      e_q    = m_reg ? m_cfg : mmem[m_adr];
      chk({cur_req, " wait"}, 32'(lat_busy), 32'(e_busy));
      chk({cur_req, " oe"}, 32'(ad_oe), 32'(e_oe));
      chk({cur_req, " err"}, 32'(err), 32'(m_err));
      if (!e_oe) chk({cur_req, " idle bus"}, 32'(ad_out), 32'h0);
      else if (e_q >= 0) chk({cur_req, " data"}, 32'(ad_out), 32'(e_q));
      if (ad_oe === 1'b1) rd_q.push_back(ad_out);
      if (lat_busy === 1'b1) busy_cnt++;
    end
  end

  task automatic tick(input logic c, input logic a, input logic w, input logic [15:0] d);
    @(negedge clk);
    ce_n = c; adv_n = a; we_n = w; ad_in = d;
  endtask

  task automatic idle();
    tick(1'b1, 1'b1, 1'b1, 16'h0);
  endtask

  task automatic start_burst(input logic [15:0] addr, input bit wr);
    @(negedge clk);
    busy_cnt = 0;
    rd_q.delete();
    ce_n = 1'b0; adv_n = 1'b0; we_n = !wr; ad_in = addr;
  endtask

  task automatic wr_burst(input logic [15:0] addr, input int lat, input int n, input logic [15:0] base);
    start_burst(addr, 1'b1);
    repeat (lat - 1) tick(1'b0, 1'b1, 1'b0, 16'hDEAD);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, dval(base, i));
  endtask

  task automatic rd_burst(input logic [15:0] addr, input int lat, input int n);
    start_burst(addr, 1'b0);
    repeat (lat - 1 + n) tick(1'b0, 1'b1, 1'b1, 16'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mmem[i] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and default configuration
    chk("R1 wait", 32'(lat_busy), 0);
    chk("R1 oe", 32'(ad_oe), 0);
    chk("R1 err", 32'(err), 0);
    cur_req = "R10 register read";
    rd_burst(16'h8000, 4, 4); idle();
    for (int k = 0; k < 4; k++) chk("R1 R10 default config", 32'(qat(k)), 32'h0014);

    // R2/R3: write then read a fixed 4-word burst at latency 4
    cur_req = "R2 write burst";
    wr_burst(16'h0002, 4, 4, 16'hA000);
    chk("R3 wait cycles lat4", busy_cnt, 3);
    idle();
    cur_req = "R2 read burst";
    rd_burst(16'h0002, 4, 4); idle();
    for (int k = 0; k < 4; k++) chk("R2 readback", 32'(qat(k)), 32'(dval(16'hA000, k)));

    // R9: register write burst keeps only the first word
    cur_req = "R9 register write";
    wr_burst(16'h8000, 4, 4, 16'h0023);
    chk("R9 err raised", 32'(err), 1);
    idle();

    // R11: new latency 3 and 8-word bursts apply at the next start
    cur_req = "R11 new config";
    rd_burst(16'h8000, 3, 1);
    chk("R9 err cleared on start", 32'(err), 0);
    idle();
    chk("R9 first word stored", 32'(qat(0)), 32'h0023);
    chk("R11 wait cycles lat3", busy_cnt, 2);

    // R5/R4: fixed 8-word write wrapping past the RAM end, then extra words
    cur_req = "R5 linear wrap";
    wr_burst(16'h007C, 3, 8, 16'h1000);
    tick(1'b0, 1'b1, 1'b0, 16'hEEEE);
    chk("R4 idle after fixed end", 32'(lat_busy), 0);
    tick(1'b0, 1'b1, 1'b0, 16'hEEEE);
    idle();
    rd_burst(16'h007C, 3, 8); idle();
    chk("R4 eight words", rd_q.size(), 8);
    for (int k = 0; k < 8; k++) chk("R5 wrapped readback", 32'(qat(k)), 32'(dval(16'h1000, k)));
    cur_req = "R4 ignored words";
    rd_burst(16'h0002, 3, 4); idle();
    chk("R5 word at 0x02", 32'(qat(0)), 32'(dval(16'h1000, 6)));
    chk("R5 word at 0x03", 32'(qat(1)), 32'(dval(16'h1000, 7)));
    chk("R4 0x04 untouched", 32'(qat(2)), 32'(dval(16'hA000, 2)));
    chk("R4 0x05 untouched", 32'(qat(3)), 32'(dval(16'hA000, 3)));

    // R6: continuous, latency 5, 40 words from 0x25 wrap within 0x20-0x3F
    cur_req = "R6 config";
    wr_burst(16'h8000, 3, 1, 16'h0005); idle();
    cur_req = "R6 continuous write";
    wr_burst(16'h0025, 5, 40, 16'h4000); idle();
    cur_req = "R6 continuous read";
    rd_burst(16'h003E, 5, 4); idle();
    chk("R3 wait cycles lat5", busy_cnt, 4);
    for (int k = 0; k < 4; k++) chk("R6 region wrap", 32'(qat(k)), 32'(dval(16'h4000, 25 + k)));
    rd_burst(16'h0025, 5, 1); idle();
    chk("R6 overwrite after wrap", 32'(qat(0)), 32'(dval(16'h4000, 32)));

    // R7: clock held low, then high, in a continuous read
    cur_req = "R7 clock stop";
    rd_burst(16'h0030, 5, 2);
    @(negedge clk); clk_run = 1'b0; #200; clk_run = 1'b1;
    tick(1'b0, 1'b1, 1'b1, 16'h0);
    tick(1'b0, 1'b1, 1'b1, 16'h0);
    @(posedge clk); #2; clk_run = 1'b0; #200; clk_run = 1'b1;
    repeat (3) tick(1'b0, 1'b1, 1'b1, 16'h0);
    idle();
    for (int k = 0; k < 6; k++) chk("R7 sequence kept", 32'(qat(k)), 32'(dval(16'h4000, 11 + k)));

    // R8: abort during latency and during data
    cur_req = "R8 abort";
    start_burst(16'h0030, 1'b0);
    tick(1'b0, 1'b1, 1'b1, 16'h0);
    idle();
    @(posedge clk); #5;
    chk("R8 wait low after abort", 32'(lat_busy), 0);
    rd_burst(16'h0030, 5, 1);
    @(negedge clk);
    chk("R3 oe before abort", 32'(ad_oe), 1);
    ce_n = 1'b1;
    #1 chk("R8 oe drops at once", 32'(ad_oe), 0);
    @(posedge clk); #5;
    chk("R8 idle after edge", 32'(ad_oe | lat_busy), 0);

    // R3 clamp: latency field 1 acts as 3; R10 reads the register
    cur_req = "R3 clamp";
    wr_burst(16'h8000, 5, 1, 16'h0011); idle();
    rd_burst(16'h8000, 3, 4); idle();
    chk("R3 clamped wait cycles", busy_cnt, 2);
    chk("R4 four words", rd_q.size(), 4);
    for (int k = 0; k < 4; k++) chk("R10 config per word", 32'(qat(k)), 32'h0011);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule